// File: doc/BRIEF.md
# Banked Register File with Pointer Window

This block is the 8-bit register file of a small accumulator-style microcontroller core. The core addresses it with a 5-bit register number through one direct port. Reads are combinational and writes take effect on the rising clock edge. A small group of low addresses holds special-purpose registers, one of which is a pointer. The rest of the space is general-purpose RAM.

Address 0 is a window, not a storage location. Any access to it goes to the register named by the low five bits of the pointer (address 4). The pointer's top three bits choose a bank. Registers 16 to 31 are banked: each bank has its own storage, and the pointer's bank bits select which one both direct and windowed accesses reach. Registers 0 to 15 are the same in every bank. The pointer and its bank field are brought out to the core.

An option register and three port-direction registers have no register number. A dedicated strobe copies the accumulator into the option register. A second strobe with a 1-based index copies the accumulator into one direction register.

Top module: `bankreg_file`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is active, and after it is released, the pointer (address 4) reads 0x00, `bank_out` is 0, the other special registers (addresses 1–7) read 0x00, and `opt_out` and every byte of `tris_out` are 0xFF.
- R2: A direct write with `we` high to address 1–3, 4 or 5–15 lands at the rising edge, and a later read of that address returns the written byte combinationally.
- R3: An access to address 0 acts on the register whose number is `ptr_out[4:0]`: a read returns that register and a write updates it.
- R4: When `ptr_out[4:0]` is 0, a read of address 0 returns 0x00 and a write to address 0 changes no register.
- R5: For addresses 16–31, the bank is `ptr_out[7:5]`. The same address in different banks is separate storage.
- R6: Addresses 0–15 reach the same storage whatever the bank bits are.
- R7: A windowed access whose target is in 16–31 uses the bank from `ptr_out[7:5]`.
- R8: `opt_ld` high at a rising edge copies `acc` into `opt_out`. Otherwise `opt_out` holds.
- R9: `tris_ld` high with `tris_sel` 1, 2 or 3 copies `acc` into direction register 1, 2 or 3 at the edge. Register k sits in `tris_out[8k-1:8k-8]`. The other direction registers hold. `tris_sel` 0 changes nothing.
- R10: The pointer can be written directly at address 4, or through the window when `ptr_out[4:0]` is 4. `ptr_out` and `bank_out` show the new value after that edge.
- R11: With `we` low, no register changes, whatever `addr` and `wdata` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register number for the direct port |
| wdata | input | 8 | Write data |
| we | input | 1 | Write enable |
| rdata | output | 8 | Combinational read data |
| acc | input | 8 | Accumulator value for the control-register strobes |
| opt_ld | input | 1 | Load option register from `acc` |
| tris_ld | input | 1 | Load the direction register chosen by `tris_sel` |
| tris_sel | input | 2 | Direction register index, 1 to 3 (0 does nothing) |
| ptr_out | output | 8 | Current pointer value |
| bank_out | output | 3 | Current bank (top pointer bits) |
| opt_out | output | 8 | Option register |
| tris_out | output | 24 | Direction registers 3, 2, 1 from high byte to low |

## Verification
The bound checker runs on every cycle. It checks the reset values when reset is released. It checks that the null window reads zero. It checks that the option and direction registers load only on their strobes and with the strobe's value. It checks that the pointer changes only on a write and takes the data of a direct write.

Some behaviours depend on storage contents, and only the bench's scenarios can show them. These are windowed aliasing, the separation of the banks, the global lower half staying the same under a changed bank, the write through the window to the pointer itself, and the discarded null-window write.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    // Where a resolved access lands
    typedef enum logic [1:0] {
        TGT_NULL    = 2'd0,   // window pointing at itself
        TGT_SPECIAL = 2'd1,   // special-purpose register slot
        TGT_RAM     = 2'd2    // general-purpose RAM (global or banked)
    } tgt_e;

endpackage

// File: rtl/bankreg_resolve.sv
module bankreg_resolve
    import bankreg_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int NUM_SPECIAL = 8,
    parameter int WIN_ADDR    = 0,
    parameter int SPEC_IW     = 3,
    parameter int RAM_IW      = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  ptr,
    output tgt_e               tgt,
    output logic [SPEC_IW-1:0] spec_idx,
    output logic [RAM_IW-1:0]  ram_idx
);

    localparam int HALF     = 2 ** (ADDR_W - 1);
    localparam int BANK_W   = DATA_W - ADDR_W;
    localparam int GLOBAL_N = HALF - NUM_SPECIAL;

    logic [ADDR_W-1:0] eff;
    logic [BANK_W-1:0] bank;
    int                lin;

    always_comb begin
        // Address 0 is the window: follow the pointer
        if (addr == ADDR_W'(WIN_ADDR)) begin
            eff = ptr[ADDR_W-1:0];
        end else begin
            eff = addr;
        end
        bank     = ptr[DATA_W-1 -: BANK_W];
        spec_idx = eff[SPEC_IW-1:0];
        lin      = 0;
        if (eff == ADDR_W'(WIN_ADDR)) begin
            tgt = TGT_NULL;
        end else if (int'(eff) < NUM_SPECIAL) begin
            tgt = TGT_SPECIAL;
        end else begin
            tgt = TGT_RAM;
            if (!eff[ADDR_W-1]) begin
                lin = int'(eff) - NUM_SPECIAL;
            end else begin
                lin = GLOBAL_N + int'(bank) * HALF + int'(eff[ADDR_W-2:0]);
            end
        end
        ram_idx = RAM_IW'(lin);
    end

endmodule

// File: rtl/bankreg_special.sv
module bankreg_special #(
    parameter int DATA_W      = 8,
    parameter int NUM_SPECIAL = 8,
    parameter int SPEC_IW     = 3,
    parameter int WIN_ADDR    = 0,
    parameter int PTR_ADDR    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [SPEC_IW-1:0] idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [DATA_W-1:0]  ptr
);

    typedef struct packed {
        logic [NUM_SPECIAL-1:0][DATA_W-1:0] r;
    } spec_t;

    spec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (idx != SPEC_IW'(WIN_ADDR)) && (int'(idx) < NUM_SPECIAL)) begin
            st_d.r[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (int'(idx) < NUM_SPECIAL) begin
            rdata = st_q.r[idx];
        end else begin
            rdata = '0;
        end
    end

    assign ptr = st_q.r[PTR_ADDR];

endmodule

// File: rtl/bankreg_ram.sv
module bankreg_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 136,
    parameter int IW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              in_range;

    assign in_range = (int'(idx) < DEPTH);

    always_comb begin
        mem_d = mem_q;
        if (we && in_range) begin
            mem_d[idx] = wdata;
        end
    end

    // No reset: contents are undefined until written
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = in_range ? mem_q[idx] : '0;

endmodule

// File: rtl/bankreg_ctl.sv
module bankreg_ctl #(
    parameter int DATA_W   = 8,
    parameter int NUM_TRIS = 3,
    parameter int SEL_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DATA_W-1:0]          acc,
    input  logic                       opt_ld,
    input  logic                       tris_ld,
    input  logic [SEL_W-1:0]           tris_sel,
    output logic [DATA_W-1:0]          opt,
    output logic [NUM_TRIS*DATA_W-1:0] tris
);

    typedef struct packed {
        logic [DATA_W-1:0]                opt;
        logic [NUM_TRIS-1:0][DATA_W-1:0]  tris;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [NUM_TRIS-1:0] hit;

    // One select decoder per direction register, index is 1-based
    for (genvar g = 0; g < NUM_TRIS; g++) begin : g_sel
        assign hit[g] = tris_ld && (tris_sel == SEL_W'(g + 1));
    end

    always_comb begin
        st_d = st_q;
        if (opt_ld) begin
            st_d.opt = acc;
        end
        for (int i = 0; i < NUM_TRIS; i++) begin
            if (hit[i]) begin
                st_d.tris[i] = acc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;   // option all ones, every pin an input
        end else begin
            st_q <= st_d;
        end
    end

    assign opt  = st_q.opt;
    assign tris = st_q.tris;

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int NUM_SPECIAL = 8,
    parameter int WIN_ADDR    = 0,
    parameter int PTR_ADDR    = 4,
    parameter int NUM_TRIS    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              we,
    output logic [DATA_W-1:0]                 rdata,
    input  logic [DATA_W-1:0]                 acc,
    input  logic                              opt_ld,
    input  logic                              tris_ld,
    input  logic [$clog2(NUM_TRIS+1)-1:0]     tris_sel,
    output logic [DATA_W-1:0]                 ptr_out,
    output logic [DATA_W-ADDR_W-1:0]          bank_out,
    output logic [DATA_W-1:0]                 opt_out,
    output logic [NUM_TRIS*DATA_W-1:0]        tris_out
);

    localparam int HALF      = 2 ** (ADDR_W - 1);
    localparam int BANK_W    = DATA_W - ADDR_W;
    localparam int NBANKS    = 2 ** BANK_W;
    localparam int RAM_DEPTH = (HALF - NUM_SPECIAL) + HALF * NBANKS;
    localparam int RAM_IW    = $clog2(RAM_DEPTH);
    localparam int SPEC_IW   = $clog2(NUM_SPECIAL);
    localparam int SEL_W     = $clog2(NUM_TRIS + 1);

    tgt_e               tgt;
    logic [SPEC_IW-1:0] spec_idx;
    logic [RAM_IW-1:0]  ram_idx;
    logic [DATA_W-1:0]  ptr;
    logic [DATA_W-1:0]  spec_rd;
    logic [DATA_W-1:0]  ram_rd;
    logic               spec_we;
    logic               ram_we;

    bankreg_resolve #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .NUM_SPECIAL (NUM_SPECIAL),
        .WIN_ADDR    (WIN_ADDR),
        .SPEC_IW     (SPEC_IW),
        .RAM_IW      (RAM_IW)
    ) u_resolve (
        .addr     (addr),
        .ptr      (ptr),
        .tgt      (tgt),
        .spec_idx (spec_idx),
        .ram_idx  (ram_idx)
    );

    assign spec_we = we && (tgt == TGT_SPECIAL);
    assign ram_we  = we && (tgt == TGT_RAM);

    bankreg_special #(
        .DATA_W      (DATA_W),
        .NUM_SPECIAL (NUM_SPECIAL),
        .SPEC_IW     (SPEC_IW),
        .WIN_ADDR    (WIN_ADDR),
        .PTR_ADDR    (PTR_ADDR)
    ) u_special (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (spec_we),
        .idx   (spec_idx),
        .wdata (wdata),
        .rdata (spec_rd),
        .ptr   (ptr)
    );

    bankreg_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (RAM_DEPTH),
        .IW     (RAM_IW)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (ram_idx),
        .wdata (wdata),
        .rdata (ram_rd)
    );

    bankreg_ctl #(
        .DATA_W   (DATA_W),
        .NUM_TRIS (NUM_TRIS),
        .SEL_W    (SEL_W)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .opt_ld   (opt_ld),
        .tris_ld  (tris_ld),
        .tris_sel (tris_sel),
        .opt      (opt_out),
        .tris     (tris_out)
    );

    always_comb begin
        unique case (tgt)
            TGT_SPECIAL: rdata = spec_rd;
            TGT_RAM:     rdata = ram_rd;
            default:     rdata = '0;
        endcase
    end

    assign ptr_out  = ptr;
    assign bank_out = ptr[DATA_W-1 -: BANK_W];

endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk #(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8,
    parameter int WIN_ADDR = 0,
    parameter int PTR_ADDR = 4,
    parameter int NUM_TRIS = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ADDR_W-1:0]             addr,
    input logic [DATA_W-1:0]             wdata,
    input logic                          we,
    input logic [DATA_W-1:0]             rdata,
    input logic [DATA_W-1:0]             acc,
    input logic                          opt_ld,
    input logic                          tris_ld,
    input logic [$clog2(NUM_TRIS+1)-1:0] tris_sel,
    input logic [DATA_W-1:0]             ptr_out,
    input logic [DATA_W-1:0]             opt_out,
    input logic [NUM_TRIS*DATA_W-1:0]    tris_out
);

    // R1: reset values visible at the first edge after release
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ptr_out == '0 && opt_out == '1 && tris_out == '1));

    // R4: self-pointing window reads zero
    a_r4_null_read: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(WIN_ADDR) && ptr_out[ADDR_W-1:0] == ADDR_W'(WIN_ADDR))
        |-> rdata == '0);

    // R8: option register loads from the accumulator
    a_r8_opt_load: assert property (@(posedge clk) disable iff (!rst_n)
        opt_ld |=> opt_out == $past(acc));

    // R8: option register holds without its strobe
    a_r8_opt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_ld |=> $stable(opt_out));

    // R9: index 1 loads the lowest direction byte
    a_r9_tris1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tris_ld && tris_sel == 1) |=> tris_out[DATA_W-1:0] == $past(acc));

    // R9: no strobe or index 0 leaves the direction registers unchanged
    a_r9_tris_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tris_ld || tris_sel == 0) |=> $stable(tris_out));

    // R10: direct pointer write takes the write data
    a_r10_ptr_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(PTR_ADDR)) |=> ptr_out == $past(wdata));

    // R11: pointer is stable when no write is made
    a_r11_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(ptr_out));

endmodule

bind bankreg_file bankreg_file_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WIN_ADDR (WIN_ADDR),
    .PTR_ADDR (PTR_ADDR),
    .NUM_TRIS (NUM_TRIS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .we       (we),
    .rdata    (rdata),
    .acc      (acc),
    .opt_ld   (opt_ld),
    .tris_ld  (tris_ld),
    .tris_sel (tris_sel),
    .ptr_out  (ptr_out),
    .opt_out  (opt_out),
    .tris_out (tris_out)
);

// File: tb/tb_bankreg_file.sv
module tb_bankreg_file;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  addr;
    logic [7:0]  wdata;
    logic        we;
    logic [7:0]  rdata;
    logic [7:0]  acc;
    logic        opt_ld;
    logic        tris_ld;
    logic [1:0]  tris_sel;
    logic [7:0]  ptr_out;
    logic [2:0]  bank_out;
    logic [7:0]  opt_out;
    logic [23:0] tris_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bankreg_file dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .we       (we),
        .rdata    (rdata),
        .acc      (acc),
        .opt_ld   (opt_ld),
        .tris_ld  (tris_ld),
        .tris_sel (tris_sel),
        .ptr_out  (ptr_out),
        .bank_out (bank_out),
        .opt_out  (opt_out),
        .tris_out (tris_out)
    );

    typedef struct packed {
        logic       we;
        logic [4:0] a;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] req;
    } step_t;

    function automatic step_t wr(logic [4:0] a, logic [7:0] d, logic [3:0] r);
        return '{we: 1'b1, a: a, wd: d, chk: 1'b0, exp: 8'h00, req: r};
    endfunction

    function automatic step_t rd(logic [4:0] a, logic [7:0] e, logic [3:0] r);
        return '{we: 1'b0, a: a, wd: 8'hEE, chk: 1'b1, exp: e, req: r};
    endfunction

    localparam int NV = 39;
    localparam step_t VEC [NV] = '{
        wr(5'd8,  8'hA5, 4'd2),   // R2 global RAM
        rd(5'd8,  8'hA5, 4'd2),   // R2
        wr(5'd15, 8'h3C, 4'd2),   // R2
        rd(5'd15, 8'h3C, 4'd2),   // R2
        wr(5'd5,  8'h9C, 4'd2),   // R2 special slot
        rd(5'd5,  8'h9C, 4'd2),   // R2
        wr(5'd4,  8'h08, 4'd10),  // R10 pointer -> reg 8, bank 0
        rd(5'd4,  8'h08, 4'd10),  // R10
        rd(5'd0,  8'hA5, 4'd3),   // R3 window reads reg 8
        wr(5'd0,  8'h5A, 4'd3),   // R3 window writes reg 8
        rd(5'd8,  8'h5A, 4'd3),   // R3
        wr(5'd4,  8'h30, 4'd5),   // R5 bank 1, target 16
        wr(5'd16, 8'h11, 4'd5),   // R5
        wr(5'd4,  8'h50, 4'd5),   // R5 bank 2, target 16
        wr(5'd16, 8'h22, 4'd5),   // R5
        rd(5'd16, 8'h22, 4'd5),   // R5
        rd(5'd0,  8'h22, 4'd7),   // R7 window into bank 2
        rd(5'd8,  8'h5A, 4'd6),   // R6 global under bank 2
        rd(5'd15, 8'h3C, 4'd6),   // R6
        wr(5'd4,  8'h30, 4'd5),   // R5 back to bank 1
        rd(5'd16, 8'h11, 4'd5),   // R5 separate storage
        wr(5'd0,  8'h77, 4'd7),   // R7 window write into bank 1
        rd(5'd16, 8'h77, 4'd7),   // R7
        wr(5'd31, 8'hE1, 4'd5),   // R5 top of bank 1
        rd(5'd31, 8'hE1, 4'd5),   // R5
        wr(5'd4,  8'h20, 4'd4),   // R4 pointer at the window itself
        rd(5'd0,  8'h00, 4'd4),   // R4 null read
        wr(5'd0,  8'hFF, 4'd4),   // R4 discarded write
        rd(5'd4,  8'h20, 4'd4),   // R4 pointer untouched
        rd(5'd16, 8'h77, 4'd4),   // R4
        rd(5'd31, 8'hE1, 4'd4),   // R4
        wr(5'd4,  8'h24, 4'd10),  // R10 pointer targets itself
        rd(5'd0,  8'h24, 4'd10),  // R10 window shows pointer
        wr(5'd0,  8'h50, 4'd10),  // R10 write pointer through window
        rd(5'd4,  8'h50, 4'd10),  // R10
        rd(5'd0,  8'h22, 4'd7),   // R7 bank 2 reg 16 via window
        rd(5'd8,  8'h5A, 4'd11),  // R11 we low with stray data
        rd(5'd8,  8'h5A, 4'd11),  // R11
        rd(5'd5,  8'h9C, 4'd6)    // R6 special under bank 2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        we = 1'b0; opt_ld = 1'b0; tris_ld = 1'b0; tris_sel = 2'd0;
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; wdata = '0; acc = '0;
        idle();
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 ptr in reset", 32'(ptr_out), 32'h00);
        check("R1 tris in reset", 32'(tris_out), 32'hFFFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ptr", 32'(ptr_out), 32'h00);
        check("R1 bank", 32'(bank_out), 32'h0);
        check("R1 opt", 32'(opt_out), 32'hFF);
        check("R1 tris", 32'(tris_out), 32'hFFFFFF);
        addr = 5'd5; #2;
        check("R1 special 5", 32'(rdata), 32'h00);

        // table walk: drive at negedge, sample reads before next edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            we = VEC[i].we; addr = VEC[i].a; wdata = VEC[i].wd;
            #2;
            if (VEC[i].chk) begin
                n_checks++;
                if (rdata !== VEC[i].exp) begin
                    n_fails++;
                    $display("FAIL R%0d step %0d: actual %h expected %h",
                             VEC[i].req, i, rdata, VEC[i].exp);
                end
            end
        end
        @(negedge clk);
        idle();
        check("R10 ptr_out", 32'(ptr_out), 32'h50);
        check("R10 bank_out", 32'(bank_out), 32'h2);

        // R8 option load
        acc = 8'h3A; opt_ld = 1'b1;
        @(negedge clk); idle();
        check("R8 opt load", 32'(opt_out), 32'h3A);
        check("R9 tris untouched by opt", 32'(tris_out), 32'hFFFFFF);

        // R9 direction registers
        acc = 8'h12; tris_ld = 1'b1; tris_sel = 2'd2;
        @(negedge clk); idle();
        check("R9 tris sel 2", 32'(tris_out), 32'hFF12FF);
        check("R8 opt hold", 32'(opt_out), 32'h3A);
        acc = 8'h00; tris_ld = 1'b1; tris_sel = 2'd0;
        @(negedge clk); idle();
        check("R9 tris sel 0 ignored", 32'(tris_out), 32'hFF12FF);
        acc = 8'h34; tris_ld = 1'b1; tris_sel = 2'd3;
        @(negedge clk); idle();
        check("R9 tris sel 3", 32'(tris_out), 32'h3412FF);
        acc = 8'h56; tris_ld = 1'b1; tris_sel = 2'd1;
        @(negedge clk); idle();
        check("R9 tris sel 1", 32'(tris_out), 32'h341256);

        // R1 reset again mid-run
        rst_n = 1'b0; #2;
        check("R1 ptr re-reset", 32'(ptr_out), 32'h00);
        check("R1 opt re-reset", 32'(opt_out), 32'hFF);
        check("R1 tris re-reset", 32'(tris_out), 32'hFFFFFF);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        addr = 5'd4; #2;
        check("R1 ptr read after reset", 32'(rdata), 32'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule